// File: doc/BRIEF.md
# Video Processor Register File with Post-Reset Hold

This block is the processor-facing register side of a video controller, together with the frame timing that governs its reset behaviour. A 3-bit index picks one of eight byte registers. An access takes place on any clock edge that sees the active-low select low, and a read/write strobe gives its direction. The block decodes control, mask and scroll writes into outputs for the rendering logic. It keeps a one-byte read buffer that is refilled from the video memory data input. It also has four general storage registers that read back at their own index.

Frame timing comes from a clock divider that drives a pixel counter and a line counter. A flag flips at every frame wrap. The active-low reset returns the divider, both counters, the odd/even flag and every register to zero. Releasing reset does not free the register file at once. The control byte, the mask byte, the whole scroll state (both scroll bytes and the first/second write toggle) and the read buffer stay forced to zero until the counters first wrap back to line 0, pixel 0. A status output marks this window, and the block ignores writes to the held registers while it lasts. Asserting reset again inside the window starts the timing and the window over.

Top module: `vidproc_reghold`

## Requirements
- R1: Index values 2, 3, 4 and 6 select plain storage bytes. A write with `cs_n` low and `rw` low stores `wdata`, and a later read (`rw` high) at the same index returns it on `rdata`.
- R2: While `cs_n` is high nothing is written and `rdata` is zero, whatever `rw`, `sel` and `wdata` are.
- R3: While `rst_n` is low, the divider phase, `pix_x_o`, `line_y_o` and `frame_odd_o` are 0, every register reads 0, and `hold_active_o` is 1.
- R4: The pixel count advances once every `CLK_DIV` clocks and wraps after `PIX_PER_LINE`. The line count advances at each pixel wrap and wraps after `LINES_PER_FRAME`. `frame_odd_o` flips at each frame wrap.
- R5: After reset is released, `hold_active_o` stays high for exactly `CLK_DIV*PIX_PER_LINE*LINES_PER_FRAME` rising edges. It falls on the edge where the counters wrap to line 0, pixel 0, and it stays low until the next reset.
- R6: While held, `ctrl_o`, `mask_o`, `scroll_x_o`, `scroll_y_o`, `toggle_o` and the read buffer stay 0. Writes to indices 0, 1 and 5 are discarded, and reads of index 7 return 0 without loading the buffer.
- R7: Writes to indices 2, 3, 4 and 6 take effect during the hold window as well.
- R8: Outside the hold window, a write to index 5 stores into `scroll_x_o` when the toggle is 0 and into `scroll_y_o` when it is 1. Each such write inverts `toggle_o`.
- R9: Outside the hold window, a read of index 2 clears `toggle_o`, so the next write to index 5 goes to `scroll_x_o`.
- R10: Outside the hold window, a read of index 7 returns the buffer content and loads the buffer from `vram_rdata` on that edge.
- R11: Asserting reset during the hold window restarts the counters from zero and restarts the full-length window when reset is released.
- R12: Reads of index 0 and index 1 return the control and mask bytes. Reads of index 5 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low access select |
| rw | input | 1 | 1 = read, 0 = write |
| sel | input | 3 | Register index 0..7 |
| wdata | input | DATA_W | Write data |
| vram_rdata | input | DATA_W | Byte from video memory used to refill the read buffer |
| rdata | output | DATA_W | Read data, zero when no read is active |
| ctrl_o | output | DATA_W | Control byte |
| mask_o | output | DATA_W | Mask byte |
| scroll_x_o | output | DATA_W | First scroll byte |
| scroll_y_o | output | DATA_W | Second scroll byte |
| toggle_o | output | 1 | First/second write toggle |
| pix_x_o | output | PIX_W | Pixel counter |
| line_y_o | output | LINE_W | Line counter |
| frame_odd_o | output | 1 | Odd/even frame flag |
| hold_active_o | output | 1 | High while held registers are forced to zero |

## Verification
The assertions assume at most one access per edge. They also assume that `sel`, `rw` and `cs_n` settle well before the edge that samples them, and that reset may be asserted at any time but is released between edges. The stimulus changes every input on the falling edge and releases reset there as well. It therefore never presents a combined read and write, and never lets an access straddle a reset release. The bench runs a small configuration (divide by 2, 5 pixels, 3 lines). This lets it test every counter position and both hold windows, including the restarted one, within a few hundred clocks.

// File: rtl/vrh_pkg.sv
package vrh_pkg;
   localparam int SEL_W    = 3;
   localparam int NUM_REGS = 1 << SEL_W;

   typedef logic [SEL_W-1:0] reg_idx_t;

   localparam reg_idx_t IDX_CTRL = 3'd0;
   localparam reg_idx_t IDX_MASK = 3'd1;
   localparam reg_idx_t IDX_STAT = 3'd2;
   localparam reg_idx_t IDX_SCRL = 3'd5;
   localparam reg_idx_t IDX_DATA = 3'd7;

   typedef struct packed {
      logic     wr;
      logic     rd;
      reg_idx_t idx;
   } cpu_acc_t;

   function automatic logic is_plain(input int idx);
      return (idx == 2) || (idx == 3) || (idx == 4) || (idx == 6);
   endfunction
endpackage

// File: rtl/vrh_timing.sv
module vrh_timing #(
   parameter int CLK_DIV         = 4,
   parameter int PIX_PER_LINE    = 341,
   parameter int LINES_PER_FRAME = 262,
   parameter int PH_W            = 2,
   parameter int PIX_W           = 9,
   parameter int LINE_W          = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [PIX_W-1:0]  pix_x,
   output logic [LINE_W-1:0] line_y,
   output logic              frame_odd,
   output logic              hold_active
);
   localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(CLK_DIV - 1);
   localparam logic [PIX_W-1:0]  PIX_LAST  = PIX_W'(PIX_PER_LINE - 1);
   localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES_PER_FRAME - 1);

   logic [PH_W-1:0] phase_q;
   logic            ph_end, pix_end, line_end;

   assign ph_end   = (phase_q == PH_LAST);
   assign pix_end  = (pix_x == PIX_LAST);
   assign line_end = (line_y == LINE_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= '0;
         pix_x       <= '0;
         line_y      <= '0;
         frame_odd   <= 1'b0;
         hold_active <= 1'b1;
      end else if (!ph_end) begin
         phase_q <= phase_q + 1'b1;
      end else begin
         phase_q <= '0;
         if (!pix_end) begin
            pix_x <= pix_x + 1'b1;
         end else begin
            pix_x <= '0;
            if (!line_end) begin
               line_y <= line_y + 1'b1;
            end else begin
               line_y      <= '0;
               frame_odd   <= ~frame_odd;
               hold_active <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/vrh_regs.sv
module vrh_regs
   import vrh_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  cpu_acc_t          acc,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] vram_rdata,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] mask_q,
   output logic [DATA_W-1:0] scroll_x_q,
   output logic [DATA_W-1:0] scroll_y_q,
   output logic              toggle_q,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] rbuf_q;
   logic [NUM_REGS-1:0][DATA_W-1:0] store_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         mask_q     <= '0;
         scroll_x_q <= '0;
         scroll_y_q <= '0;
         toggle_q   <= 1'b0;
         rbuf_q     <= '0;
      end else if (hold) begin
         ctrl_q     <= '0;
         mask_q     <= '0;
         scroll_x_q <= '0;
         scroll_y_q <= '0;
         toggle_q   <= 1'b0;
         rbuf_q     <= '0;
      end else begin
         if (acc.wr && acc.idx == IDX_CTRL) ctrl_q <= wdata;
         if (acc.wr && acc.idx == IDX_MASK) mask_q <= wdata;
         if (acc.wr && acc.idx == IDX_SCRL) begin
            if (toggle_q) scroll_y_q <= wdata;
            else          scroll_x_q <= wdata;
            toggle_q <= ~toggle_q;
         end else if (acc.rd && acc.idx == IDX_STAT) begin
            toggle_q <= 1'b0;
         end
         if (acc.rd && acc.idx == IDX_DATA) rbuf_q <= vram_rdata;
      end
   end

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_store
      if (is_plain(gi)) begin : g_plain
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                     q <= '0;
            else if (acc.wr && acc.idx == reg_idx_t'(gi))   q <= wdata;
         end
         assign store_q[gi] = q;
      end else begin : g_none
         assign store_q[gi] = '0;
      end
   end

   always_comb begin
      rdata = '0;
      if (acc.rd) begin
         unique case (acc.idx)
            IDX_CTRL: rdata = ctrl_q;
            IDX_MASK: rdata = mask_q;
            IDX_SCRL: rdata = '0;
            IDX_DATA: rdata = rbuf_q;
            default:  rdata = store_q[acc.idx];
         endcase
      end
   end
endmodule

// File: rtl/vidproc_reghold.sv
module vidproc_reghold
   import vrh_pkg::*;
#(
   parameter int DATA_W          = 8,
   parameter int CLK_DIV         = 4,
   parameter int PIX_PER_LINE    = 341,
   parameter int LINES_PER_FRAME = 262,
   localparam int PH_W   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1,
   localparam int PIX_W  = $clog2(PIX_PER_LINE),
   localparam int LINE_W = $clog2(LINES_PER_FRAME)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rw,
   input  logic [2:0]        sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] vram_rdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] ctrl_o,
   output logic [DATA_W-1:0] mask_o,
   output logic [DATA_W-1:0] scroll_x_o,
   output logic [DATA_W-1:0] scroll_y_o,
   output logic              toggle_o,
   output logic [PIX_W-1:0]  pix_x_o,
   output logic [LINE_W-1:0] line_y_o,
   output logic              frame_odd_o,
   output logic              hold_active_o
);
   if (CLK_DIV < 1 || PIX_PER_LINE < 2 || LINES_PER_FRAME < 2 || DATA_W < 1) begin : g_bad_cfg
      $error("vidproc_reghold: CLK_DIV>=1, PIX_PER_LINE>=2, LINES_PER_FRAME>=2, DATA_W>=1 required");
   end

   cpu_acc_t acc;
   assign acc.wr  = !cs_n && !rw;
   assign acc.rd  = !cs_n && rw;
   assign acc.idx = sel;

   vrh_timing #(
      .CLK_DIV(CLK_DIV), .PIX_PER_LINE(PIX_PER_LINE), .LINES_PER_FRAME(LINES_PER_FRAME),
      .PH_W(PH_W), .PIX_W(PIX_W), .LINE_W(LINE_W)
   ) u_timing (
      .clk(clk), .rst_n(rst_n), .pix_x(pix_x_o), .line_y(line_y_o),
      .frame_odd(frame_odd_o), .hold_active(hold_active_o)
   );

   vrh_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .hold(hold_active_o), .acc(acc),
      .wdata(wdata), .vram_rdata(vram_rdata),
      .ctrl_q(ctrl_o), .mask_q(mask_o), .scroll_x_q(scroll_x_o),
      .scroll_y_q(scroll_y_o), .toggle_q(toggle_o), .rdata(rdata)
   );
endmodule

// File: rtl/vidproc_reghold_chk.sv
module vidproc_reghold_chk #(
   parameter int DATA_W          = 8,
   parameter int CLK_DIV         = 4,
   parameter int PIX_PER_LINE    = 341,
   parameter int LINES_PER_FRAME = 262,
   localparam int PIX_W  = $clog2(PIX_PER_LINE),
   localparam int LINE_W = $clog2(LINES_PER_FRAME)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              rw,
   input logic [2:0]        sel,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] vram_rdata,
   input logic [DATA_W-1:0] rdata,
   input logic [DATA_W-1:0] ctrl_o,
   input logic [DATA_W-1:0] mask_o,
   input logic [DATA_W-1:0] scroll_x_o,
   input logic [DATA_W-1:0] scroll_y_o,
   input logic              toggle_o,
   input logic [PIX_W-1:0]  pix_x_o,
   input logic [LINE_W-1:0] line_y_o,
   input logic              frame_odd_o,
   input logic              hold_active_o
);
   assert_counter_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(pix_x_o) < PIX_PER_LINE) && (int'(line_y_o) < LINES_PER_FRAME));

   assert_hold_ends_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_active_o) |-> (pix_x_o == '0) && (line_y_o == '0) && frame_odd_o);

   assert_hold_never_rearms_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(hold_active_o));

   assert_held_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hold_active_o |-> (ctrl_o == '0) && (mask_o == '0) && (scroll_x_o == '0)
                        && (scroll_y_o == '0) && !toggle_o);

   assert_scroll_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !rw && sel == 3'd5 && !hold_active_o) |=> (toggle_o != $past(toggle_o)));

   assert_stat_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && rw && sel == 3'd2) |=> !toggle_o);

   assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> $stable(ctrl_o) && $stable(mask_o) && $stable(scroll_x_o) && $stable(scroll_y_o));

   assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (rdata == '0));
endmodule

bind vidproc_reghold vidproc_reghold_chk #(
   .DATA_W(DATA_W), .CLK_DIV(CLK_DIV),
   .PIX_PER_LINE(PIX_PER_LINE), .LINES_PER_FRAME(LINES_PER_FRAME)
) u_chk (.*);

// File: tb/vidproc_reghold_tb.sv
module vidproc_reghold_tb;
   localparam int PER = 10;
   localparam int DW  = 8;
   localparam int DV  = 2;
   localparam int NP  = 5;
   localparam int NL  = 3;
   localparam int FR  = DV * NP * NL;

   logic          clk = 1'b0;
   logic          rst_n, cs_n, rw;
   logic [2:0]    sel;
   logic [DW-1:0] wdata, vram_rdata, rdata;
   logic [DW-1:0] ctrl_o, mask_o, scroll_x_o, scroll_y_o;
   logic          toggle_o, frame_odd_o, hold_active_o;
   logic [2:0]    pix_x_o;
   logic [1:0]    line_y_o;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit mon_en = 1'b0;
   bit done   = 1'b0;

   always #(PER/2) clk = ~clk;

   vidproc_reghold #(.DATA_W(DW), .CLK_DIV(DV), .PIX_PER_LINE(NP), .LINES_PER_FRAME(NL)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .sel(sel), .wdata(wdata),
      .vram_rdata(vram_rdata), .rdata(rdata), .ctrl_o(ctrl_o), .mask_o(mask_o),
      .scroll_x_o(scroll_x_o), .scroll_y_o(scroll_y_o), .toggle_o(toggle_o),
      .pix_x_o(pix_x_o), .line_y_o(line_y_o), .frame_odd_o(frame_odd_o),
      .hold_active_o(hold_active_o)
   );

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // R4 R5: counters and hold flag against arithmetic model on every falling edge
   always @(negedge clk) begin
      if (mon_en && rst_n && !done) begin
         chk("R4 pix", int'(pix_x_o), (cyc / DV) % NP);
         chk("R4 line", int'(line_y_o), (cyc / (DV * NP)) % NL);
         chk("R4 odd", int'(frame_odd_o), (cyc / FR) % 2);
         chk("R5 hold", int'(hold_active_o), (cyc < FR) ? 1 : 0);
      end
   end

   task automatic wr(input int idx, input int val);
      cs_n = 1'b0; rw = 1'b0; sel = 3'(idx); wdata = DW'(val);
      @(negedge clk);
      cs_n = 1'b1; rw = 1'b1;
   endtask

   task automatic rd(input int idx, output int val);
      cs_n = 1'b0; rw = 1'b1; sel = 3'(idx);
      #(PER/4);
      val = int'(rdata);
      @(negedge clk);
      cs_n = 1'b1;
   endtask

   initial begin
      #(PER * 5000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int v;
      rst_n = 1'b0; cs_n = 1'b1; rw = 1'b1; sel = '0; wdata = '0; vram_rdata = '0;
      repeat (3) @(negedge clk);
      // R3 reset state
      chk("R3 hold", int'(hold_active_o), 1);
      chk("R3 pix", int'(pix_x_o), 0);
      chk("R3 line", int'(line_y_o), 0);
      chk("R3 odd", int'(frame_odd_o), 0);
      chk("R3 ctrl", int'(ctrl_o), 0);
      chk("R3 toggle", int'(toggle_o), 0);
      rst_n = 1'b1;
      mon_en = 1'b1;

      // R6 held registers ignore writes
      wr(0, 8'hA5); chk("R6 ctrl held", int'(ctrl_o), 0);
      wr(1, 8'h3C); chk("R6 mask held", int'(mask_o), 0);
      wr(5, 8'h12); chk("R6 scroll held", int'(scroll_x_o), 0);
      chk("R6 toggle held", int'(toggle_o), 0);
      rd(0, v); chk("R6 ctrl read held", v, 0);
      vram_rdata = 8'h77;
      rd(7, v); chk("R6 buffer read held", v, 0);
      rd(7, v); chk("R6 buffer not loaded", v, 0);

      // R7 R1 plain storage during hold
      foreach (sel[i]) begin end
      for (int i = 2; i < 7; i++) begin
         if (i != 5) wr(i, 8'h40 + i * 3);
      end
      for (int i = 2; i < 7; i++) begin
         if (i != 5) begin rd(i, v); chk("R7 R1 plain during hold", v, 8'h40 + i * 3); end
      end

      // R2 deselected access
      cs_n = 1'b1; rw = 1'b0; sel = 3'd2; wdata = 8'hFF;
      #(PER/4);
      chk("R2 rdata idle", int'(rdata), 0);
      @(negedge clk);
      rw = 1'b1;
      rd(2, v); chk("R2 no write when deselected", v, 8'h46);

      // R11 reset again inside the window
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rd(3, v); chk("R11 R3 plain cleared", v, 0);
      chk("R11 hold during reset", int'(hold_active_o), 1);
      rst_n = 1'b1;
      chk("R11 pix restart", int'(pix_x_o), 0);
      while (cyc < FR - 1) @(negedge clk);
      chk("R11 R5 hold before wrap", int'(hold_active_o), 1);
      @(negedge clk);
      chk("R5 hold released", int'(hold_active_o), 0);
      chk("R5 wrap pix", int'(pix_x_o), 0);
      chk("R5 wrap line", int'(line_y_o), 0);
      chk("R4 odd after wrap", int'(frame_odd_o), 1);

      // R12 control and mask readback
      wr(0, 8'hA5); chk("R12 ctrl out", int'(ctrl_o), 8'hA5);
      rd(0, v); chk("R12 ctrl read", v, 8'hA5);
      wr(1, 8'h3C); rd(1, v); chk("R12 mask read", v, 8'h3C);

      // R8 scroll pair
      wr(5, 8'h12);
      chk("R8 scroll x", int'(scroll_x_o), 8'h12);
      chk("R8 toggle set", int'(toggle_o), 1);
      wr(5, 8'h34);
      chk("R8 scroll y", int'(scroll_y_o), 8'h34);
      chk("R8 toggle clear", int'(toggle_o), 0);
      // R9 status read clears toggle
      wr(5, 8'h56);
      chk("R9 toggle before", int'(toggle_o), 1);
      rd(2, v);
      chk("R9 toggle cleared", int'(toggle_o), 0);
      wr(5, 8'h9A);
      chk("R9 next write to x", int'(scroll_x_o), 8'h9A);
      chk("R9 y untouched", int'(scroll_y_o), 8'h34);
      rd(5, v); chk("R12 scroll reads zero", v, 0);

      // R10 read buffer pipeline
      vram_rdata = 8'h77; rd(7, v); chk("R10 first read", v, 0);
      vram_rdata = 8'h88; rd(7, v); chk("R10 second read", v, 8'h77);
      rd(7, v); chk("R10 third read", v, 8'h88);

      // R1 R12 sweep of writable indices
      for (int i = 0; i < 7; i++) begin
         if (i != 5) begin
            for (int p = 0; p < 3; p++) begin
               int val;
               val = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (8'h5A ^ i);
               wr(i, val);
               rd(i, v);
               chk("R1 R12 sweep", v, val);
            end
         end
      end

      repeat (2 * FR) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule